// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives the switching outputs of a buck regulator that has two, three or four channels. One period counter serves every channel. Each channel reads that counter at its own phase offset, which gives it its own sawtooth. A channel's output is high while its sawtooth is below the channel's duty value. That duty value is a shared duty command plus a signed trim for the channel, clamped to the counter range. Because the channels are spaced evenly around the period, the combined ripple runs at the channel frequency times the number of active channels. For each channel, a one-cycle strobe fires a third of a period after the channel's high pulse ends, so an external sampler can measure the low-side current at that point.

The active channel count comes from the board. Unused outputs are pulled high on the board. In the first clock after reset, while every output is still undriven, the block samples those pad levels through a sense input. The result is held until the next reset. A two-bit mode input from an external sequencer selects one of three output states for all active channels: undriven (three-state), clamped low, or switching. The output-enable vector carries the three-state behaviour.

The control state machine has four states. ST_STRAP is entered by reset. It always moves to ST_OFF on the next clock and captures the channel count on that clock. From ST_OFF, ST_CLAMP and ST_RUN, every clock moves to the state that the mode input names: 01 selects ST_CLAMP, 10 selects ST_RUN, and 00 or 11 selects ST_OFF. Any of these three states can be reached from any other.

Top module: `mpwm_interleave`

## Requirements
- R1: In ST_STRAP the pad sense vector sets the active count. If the top two pads both read 1, only channels 0 and 1 are active. If only the top pad reads 1, channels 0 to 2 are active. Otherwise all four channels are active.
- R2: The pad sense input is ignored after the first clock following reset. Later changes to it alter neither the set of driven outputs nor any output value.
- R3: The period counter is 0 during reset and steps once per clock, wrapping after PERIOD-1. Channel k sees phase (counter - k*PERIOD/n) mod PERIOD, where n is the active count.
- R4: In ST_RUN an active channel's output is 1 while its phase is below its duty value and 0 otherwise. A larger duty gives a longer pulse, with no inversion.
- R5: The duty value is duty_cmd plus the channel's signed two's-complement trim (lane k in duty_trim bits [k*TRIM_W +: TRIM_W]), clamped to 0..PERIOD-1. A value of 0 gives no pulse.
- R6: The duty value is taken from the inputs in the cycle where the channel's phase is 0 and held for the rest of that period. Mid-period input changes take effect only from the channel's next phase 0.
- R7: In ST_RUN an active channel with duty value D pulses its strobe for one cycle at phase D+PERIOD/3. The strobe is suppressed when D is 0 or when D+PERIOD/3 is not below PERIOD.
- R8: The mode code applies one clock after it is presented. ST_OFF leaves all outputs undriven. ST_CLAMP drives every active output low. ST_RUN drives active outputs with their pulses. No output is 1 unless it is driven.
- R9: Inactive channels are never driven and never strobe.
- R10: During reset and in ST_STRAP, no output is driven and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 2 | Sequencer mode: 00 off, 01 clamp low, 10 switching, 11 off |
| duty_cmd | input | CNT_W (5) | Shared duty command in counter ticks |
| duty_trim | input | NCH*TRIM_W (20) | Signed per-channel duty trims, channel k at bits [k*TRIM_W +: TRIM_W] |
| pad_sense | input | NCH (4) | Sensed pad levels, used only for channel-count detection |
| pwm_out | output | NCH (4) | Output level per channel when driven |
| pwm_oe | output | NCH (4) | Drive enable per channel; 0 means three-state |
| isamp_stb | output | NCH (4) | One-cycle current-sample strobe per channel |

## Verification
All outputs are combinational functions of registered state: the counter, the control state, the detected mask and the latched duties. The only input that reaches the outputs in the same cycle is the duty inputs, and only at a channel's phase 0. A mode change presented before a clock therefore shows at the outputs only after that clock. The bench checks this explicitly by sampling once before and once after the edge. The bench drives inputs just after the falling edge and compares every output 1 ns later. Its reference model advances on the rising edge exactly as R3 and R6 specify, so each comparison falls in the cycle in which the result is due. Counts of high cycles and strobes per period check the clamp and strobe limits directly.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_OFF   = 2'd1,
        ST_CLAMP = 2'd2,
        ST_RUN   = 2'd3
    } seq_state_e;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_CLAMP = 2'b01;
    localparam logic [1:0] MODE_RUN   = 2'b10;

endpackage

// File: rtl/mpwm_phase_ctr.sv
module mpwm_phase_ctr #(
    parameter int PERIOD = 24,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mpwm_strap.sv
module mpwm_strap #(
    parameter int NCH    = 4,
    parameter int PERIOD = 24,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [NCH-1:0]   pad_sense,
    output logic [NCH-1:0]   act_mask,
    output logic [CNT_W-1:0] spacing
);
    localparam logic [CNT_W-1:0] SP_FULL = CNT_W'(PERIOD / NCH);
    localparam logic [CNT_W-1:0] SP_M1   = CNT_W'(PERIOD / (NCH - 1));
    localparam logic [CNT_W-1:0] SP_M2   = CNT_W'(PERIOD / (NCH - 2));

    logic             top_tied;
    logic             two_tied;
    logic [NCH-1:0]   mask_d;
    logic [CNT_W-1:0] sp_d;

    assign top_tied = pad_sense[NCH-1];
    assign two_tied = pad_sense[NCH-1] & pad_sense[NCH-2];

    always_comb begin
        mask_d = '1;
        sp_d   = SP_FULL;
        if (two_tied) begin
            mask_d[NCH-1] = 1'b0;
            mask_d[NCH-2] = 1'b0;
            sp_d          = SP_M2;
        end else if (top_tied) begin
            mask_d[NCH-1] = 1'b0;
            sp_d          = SP_M1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mask <= '0;
            spacing  <= SP_FULL;
        end else if (capture) begin
            act_mask <= mask_d;
            spacing  <= sp_d;
        end
    end
endmodule

// File: rtl/mpwm_lane.sv
module mpwm_lane #(
    parameter int PERIOD = 24,
    parameter int CNT_W  = $clog2(PERIOD),
    parameter int TRIM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  offset,
    input  logic [CNT_W-1:0]  duty_cmd,
    input  logic [TRIM_W-1:0] trim,
    output logic              pulse,
    output logic              strobe
);
    localparam int SW = CNT_W + 2;
    localparam logic [CNT_W:0]         PER_X  = (CNT_W+1)'(PERIOD);
    localparam logic [CNT_W:0]         THIRD  = (CNT_W+1)'(PERIOD / 3);
    localparam logic signed [SW-1:0]   S_MAX  = SW'(PERIOD - 1);
    localparam logic [CNT_W-1:0]       D_MAX  = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0]     ph;
    logic signed [SW-1:0] sum;
    logic [CNT_W-1:0]     duty_sat;
    logic [CNT_W-1:0]     duty_q;
    logic [CNT_W-1:0]     duty_use;
    logic [CNT_W:0]       stb_pt;

    always_comb begin
        if (cnt >= offset) begin
            ph = cnt - offset;
        end else begin
            ph = CNT_W'({1'b0, cnt} + PER_X - {1'b0, offset});
        end
    end

    always_comb begin
        sum = $signed({2'b00, duty_cmd})
            + $signed({{(SW-TRIM_W){trim[TRIM_W-1]}}, trim});
        if (sum < 0) begin
            duty_sat = '0;
        end else if (sum > S_MAX) begin
            duty_sat = D_MAX;
        end else begin
            duty_sat = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (ph == '0) begin
            duty_q <= duty_sat;
        end
    end

    assign duty_use = (ph == '0) ? duty_sat : duty_q;
    assign stb_pt   = {1'b0, duty_use} + THIRD;
    assign pulse    = (ph < duty_use);
    assign strobe   = (duty_use != '0) && (stb_pt < PER_X)
                   && (ph == stb_pt[CNT_W-1:0]);
endmodule

// File: rtl/mpwm_interleave.sv
module mpwm_interleave
    import mpwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int PERIOD = 24,
    parameter int TRIM_W = 5,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            run_mode,
    input  logic [CNT_W-1:0]      duty_cmd,
    input  logic [NCH*TRIM_W-1:0] duty_trim,
    input  logic [NCH-1:0]        pad_sense,
    output logic [NCH-1:0]        pwm_out,
    output logic [NCH-1:0]        pwm_oe,
    output logic [NCH-1:0]        isamp_stb
);
    seq_state_e       state;
    seq_state_e       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] spacing;
    logic [NCH-1:0]   act_mask;
    logic [NCH-1:0]   lane_pulse;
    logic [NCH-1:0]   lane_stb;

    mpwm_phase_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    mpwm_strap #(.NCH(NCH), .PERIOD(PERIOD), .CNT_W(CNT_W)) u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (state == ST_STRAP),
        .pad_sense (pad_sense),
        .act_mask  (act_mask),
        .spacing   (spacing)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        logic [CNT_W-1:0] lane_off;
        assign lane_off = CNT_W'(spacing * CNT_W'(k));

        mpwm_lane #(.PERIOD(PERIOD), .CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .offset   (lane_off),
            .duty_cmd (duty_cmd),
            .trim     (duty_trim[k*TRIM_W +: TRIM_W]),
            .pulse    (lane_pulse[k]),
            .strobe   (lane_stb[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STRAP;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = ST_OFF;
        unique case (state)
            ST_STRAP: state_nx = ST_OFF;
            ST_OFF, ST_CLAMP, ST_RUN: begin
                if (run_mode == MODE_CLAMP) begin
                    state_nx = ST_CLAMP;
                end else if (run_mode == MODE_RUN) begin
                    state_nx = ST_RUN;
                end else begin
                    state_nx = ST_OFF;
                end
            end
        endcase
    end

    always_comb begin
        pwm_oe    = '0;
        pwm_out   = '0;
        isamp_stb = '0;
        unique case (state)
            ST_STRAP, ST_OFF: ;
            ST_CLAMP: pwm_oe = act_mask;
            ST_RUN: begin
                pwm_oe    = act_mask;
                pwm_out   = lane_pulse & act_mask;
                isamp_stb = lane_stb & act_mask;
            end
        endcase
    end
endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
    import mpwm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input seq_state_e     state,
    input logic [NCH-1:0] act_mask,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] pwm_oe,
    input logic [NCH-1:0] isamp_stb
);
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STRAP && $past(state) != ST_STRAP) |-> $stable(act_mask)); // R2

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (isamp_stb & $past(isamp_stb)) == '0); // R7

    AST_STB_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (isamp_stb & pwm_out) == '0); // R7

    AST_OUT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~pwm_oe) == '0); // R8

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CLAMP |-> (pwm_out == '0 && pwm_oe == act_mask)); // R8

    AST_INACTIVE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_oe | isamp_stb) & ~act_mask) == '0); // R9

    AST_STRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STRAP |-> (pwm_oe == '0 && isamp_stb == '0)); // R10
endmodule

bind mpwm_interleave mpwm_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .act_mask  (act_mask),
    .pwm_out   (pwm_out),
    .pwm_oe    (pwm_oe),
    .isamp_stb (isamp_stb)
);

// File: tb/mpwm_interleave_test.sv
`timescale 1ns/1ps
module mpwm_interleave_test;
    localparam int P  = 24;
    localparam int TH = P / 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  run_mode = 2'b00;
    logic [4:0]  duty_cmd = '0;
    logic [19:0] duty_trim = '0;
    logic [3:0]  pad_sense = '0;
    logic [3:0]  pwm_out, pwm_oe, isamp_stb;

    int n_vec = 0;
    int n_bad = 0;
    int tr [4] = '{0, 0, 0, 0};

    int m_cnt, m_sp, m_state;
    logic [3:0] m_mask;
    int m_duty [4];

    always #2.5 clk = ~clk;

    mpwm_interleave uut (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .duty_cmd(duty_cmd),
        .duty_trim(duty_trim), .pad_sense(pad_sense), .pwm_out(pwm_out),
        .pwm_oe(pwm_oe), .isamp_stb(isamp_stb)
    );

    function automatic int sat(int cmd, int t);
        int s = cmd + t;
        if (s < 0) return 0;
        if (s > P - 1) return P - 1;
        return s;
    endfunction

    function automatic int mph(int c, int k, int sp);
        int v = c - k * sp;
        if (v < 0) v += P;
        return v;
    endfunction

    // Reference model from R1, R3, R6, R8
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_sp <= P / 4; m_state <= 0; m_mask <= 4'b0000;
            for (int k = 0; k < 4; k++) m_duty[k] <= 0;
        end else begin
            for (int k = 0; k < 4; k++)
                if (mph(m_cnt, k, m_sp) == 0) m_duty[k] <= sat(int'(duty_cmd), tr[k]);
            m_cnt <= (m_cnt + 1) % P;
            if (m_state == 0) begin
                if (pad_sense[3] && pad_sense[2]) begin m_mask <= 4'b0011; m_sp <= P / 2; end
                else if (pad_sense[3])            begin m_mask <= 4'b0111; m_sp <= P / 3; end
                else                              begin m_mask <= 4'b1111; m_sp <= P / 4; end
                m_state <= 1;
            end else begin
                m_state <= (run_mode == 2'b01) ? 2 : (run_mode == 2'b10) ? 3 : 1;
            end
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_check(input string tag);
        logic [3:0] e_out, e_oe, e_stb;
        e_out = '0; e_oe = '0; e_stb = '0;
        for (int k = 0; k < 4; k++) begin
            int p = mph(m_cnt, k, m_sp);
            int du = (p == 0) ? sat(int'(duty_cmd), tr[k]) : m_duty[k];
            if (m_state >= 2) e_oe[k] = m_mask[k];
            if (m_state == 3) begin
                e_out[k] = m_mask[k] && (p < du);
                e_stb[k] = m_mask[k] && du != 0 && (du + TH < P) && (p == du + TH);
            end
        end
        cmp(tag, "pwm_out", int'(pwm_out), int'(e_out));
        cmp(tag, "pwm_oe", int'(pwm_oe), int'(e_oe));
        cmp(tag, "isamp_stb", int'(isamp_stb), int'(e_stb));
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            model_check(tag);
        end
    endtask

    task automatic set_trims(input int a, input int b, input int c, input int d);
        tr[0] = a; tr[1] = b; tr[2] = c; tr[3] = d;
        duty_trim = {5'(d), 5'(c), 5'(b), 5'(a)};
    endtask

    task automatic drive(input logic [1:0] mode, input int cmd);
        @(negedge clk);
        run_mode = mode; duty_cmd = 5'(cmd);
    endtask

    task automatic do_reset(input logic [3:0] pads);
        @(negedge clk);
        rst_n = 1'b0; pad_sense = pads; run_mode = 2'b00;
        repeat (3) @(negedge clk);
        #1 cmp("R10", "oe in reset", int'(pwm_oe), 0);
        rst_n = 1'b1;
        #1 cmp("R10", "oe in strap", int'(pwm_oe), 0);
        cmp("R10", "stb in strap", int'(isamp_stb), 0);
    endtask

    // counts high cycles and strobes per channel over n cycles
    task automatic tally(input int n, input string tag, output int hi [4], output int st [4]);
        for (int k = 0; k < 4; k++) begin hi[k] = 0; st[k] = 0; end
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            model_check(tag);
            for (int k = 0; k < 4; k++) begin
                hi[k] += int'(pwm_out[k]);
                st[k] += int'(isamp_stb[k]);
            end
        end
    endtask

    task automatic t_detect();
        logic [3:0] pads [3] = '{4'b0000, 4'b1000, 4'b1100};
        logic [3:0] want [3] = '{4'b1111, 4'b0111, 4'b0011};
        for (int j = 0; j < 3; j++) begin
            do_reset(pads[j]);
            drive(2'b01, 6);
            run(3, "R1");
            cmp("R1", "active mask", int'(pwm_oe), int'(want[j]));
            cmp("R8", "clamp level", int'(pwm_out), 0);
        end
    endtask

    task automatic t_pad_ignore();
        int hi [4], st [4];
        do_reset(4'b1000);
        drive(2'b10, 6);
        run(P, "R2");
        pad_sense = 4'b0000;
        run(P, "R2");
        cmp("R2", "mask after pad change", int'(pwm_oe), 4'b0111);
        pad_sense = 4'b1100;
        tally(P, "R2", hi, st);
        cmp("R2", "ch2 still switching", hi[2], 6);
        cmp("R2", "ch3 still open", int'(pwm_oe[3]), 0);
    endtask

    task automatic t_phase();
        int t0, t1, i;
        do_reset(4'b1000);
        drive(2'b10, 5);
        run(2 * P, "R3");
        t0 = -1; t1 = -1; i = 0;
        while ((t0 < 0 || t1 < 0) && i < 2 * P) begin
            logic [3:0] prev = pwm_out;
            @(negedge clk); #1;
            model_check("R3");
            if (!prev[0] && pwm_out[0] && t0 < 0) t0 = i;
            if (t0 >= 0 && !prev[1] && pwm_out[1] && t1 < 0) t1 = i;
            i++;
        end
        cmp("R3", "ch0 to ch1 spacing (3 ch)", t1 - t0, P / 3);
        do_reset(4'b0000);
        drive(2'b10, 3);
        run(3 * P, "R4");
        drive(2'b10, 14);
        run(3 * P, "R4");
        set_trims(-2, 1, 3, -4);
        run(3 * P, "R4");
        set_trims(0, 0, 0, 0);
    endtask

    task automatic t_two_ch();
        int hi [4], st [4];
        do_reset(4'b1100);
        drive(2'b10, 9);
        run(P, "R9");
        tally(P, "R9", hi, st);
        cmp("R9", "ch3 pulses", hi[3] + hi[2], 0);
        cmp("R9", "ch2/3 strobes", st[2] + st[3], 0);
        cmp("R4", "ch1 on time", hi[1], 9);
    endtask

    task automatic t_sat();
        int hi [4], st [4];
        do_reset(4'b0000);
        set_trims(10, -10, 0, -16);
        drive(2'b10, 20);
        run(2 * P, "R5");
        tally(P, "R5", hi, st);
        cmp("R5", "upper clamp ch0", hi[0], P - 1);
        cmp("R5", "mid ch1", hi[1], 10);
        cmp("R5", "ch3 20-16", hi[3], 4);
        drive(2'b10, 3);
        run(2 * P, "R5");
        tally(P, "R5", hi, st);
        cmp("R5", "zero clamp ch1 no pulse", hi[1], 0);
        cmp("R5", "zero clamp ch1 no strobe", st[1], 0);
        cmp("R5", "ch0 3+10", hi[0], 13);
        set_trims(0, 0, 0, 0);
    endtask

    task automatic t_latch();
        do_reset(4'b0000);
        drive(2'b10, 6);
        run(P + 5, "R6");
        duty_cmd = 5'd18;
        run(3, "R6");
        duty_cmd = 5'd2;
        run(P + 7, "R6");
        duty_cmd = 5'd11;
        run(2 * P, "R6");
    endtask

    task automatic t_strobe();
        int hi [4], st [4];
        do_reset(4'b0000);
        drive(2'b10, 4);
        run(P, "R7");
        tally(P, "R7", hi, st);
        cmp("R7", "one strobe per period", st[0] + st[1] + st[2] + st[3], 4);
        drive(2'b10, 15);
        run(P, "R7");
        tally(P, "R7", hi, st);
        cmp("R7", "strobe at last phase", st[2], 1);
        drive(2'b10, 16);
        run(P, "R7");
        tally(P, "R7", hi, st);
        cmp("R7", "strobe past period suppressed", st[0] + st[1] + st[2] + st[3], 0);
    endtask

    task automatic t_modes();
        do_reset(4'b0000);
        drive(2'b01, 8);
        run(2, "R8");
        drive(2'b11, 8);
        #1 cmp("R8", "old state before edge", int'(pwm_oe), 4'b1111);
        run(2, "R8");
        cmp("R8", "mode 11 open", int'(pwm_oe), 0);
        drive(2'b10, 8);
        #1 cmp("R8", "still open before edge", int'(pwm_oe), 0);
        run(2 * P, "R8");
        drive(2'b00, 8);
        run(3, "R8");
        cmp("R8", "off open", int'(pwm_oe) | int'(pwm_out), 0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_detect();
        t_pad_ignore();
        t_phase();
        t_two_ch();
        t_sat();
        t_latch();
        t_strobe();
        t_modes();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule